// File: doc/BRIEF.md
# Audio DMA Address Generator

This block produces the memory addresses for one streaming audio channel whose samples sit in a contiguous ring buffer. Software programs a start address, an end (protection) address, a period size code and the burst and threshold codes. Once transfers are enabled, the block asks the bus master for one dword beat at a time. Each acknowledged beat moves the live pointer forward by four bytes. When the pointer would reach the protection address, it returns to the start address instead.

A period interrupt marks the moment the pointer steps onto an address aligned to a programmable power-of-two range. Software clears it by writing a one to the status register. The control register has a write-enable mask, so single bits can be set or cleared without a read-modify-write. The live pointer and the offset into the buffer can both be read back.

Register map (word index on `regAddr`): 0 control, 1 status, 2 start address, 3 protection address, 4 page word, 5 transfer config, 6 live pointer (read only), 7 buffer offset (read only).

Top module: `audio_dma_addrgen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the control register, the status register, the start address and the protection address, and sets the live pointer to 0. After that edge, `beatReq` and `irq` read 0.
- R2: A write to the control register changes low bit i only where bit i+16 of the written word is 1; that bit takes the value of written bit i. Control bit 0 is the transfer enable. Writing 0x00010001 sets it, 0x00010000 clears it, and 0x00000001 leaves it unchanged.
- R3: `beatReq` is 1 only when three conditions hold together: the transfer enable is 1, page bit 11 (the paging enable) is 0, and `fifoLevel` is at least the threshold count. The threshold count comes from config bits 5:4: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16.
- R4: Each edge with `beatReq` and `beatAck` both high advances the live pointer (`beatAddr`, register 6) by 4. Without an acknowledged beat, the pointer holds.
- R5: When the advanced value equals the protection address, the pointer loads the start address instead.
- R6: With limit code L = page bits 7:4 in the range 1 to 15, an acknowledged beat whose advanced value (taken before the wrap) has its low 5+L bits all zero sets status bit 0. With L = 0, no period interrupt is raised.
- R7: Writing status with bit 0 = 1 clears the pending flag, and writing 0 there leaves it unchanged. When a set and a clear fall in the same cycle, the set wins. `irq` equals status bit 0.
- R8: Writing the start address while the transfer enable is 0 also loads the live pointer with the written value. While the enable is 1, the pointer is unaffected. Writes to registers 6 and 7 have no effect.
- R9: `burstDwords` equals 2 to the power of config bits 2:0, giving 1 to 128.
- R10: Register 7 reads the live pointer minus the start address. When that difference equals the protection address minus the start address, it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| fifoLevel | input | 8 | Dwords of data (to memory) or free space (from memory) in the port FIFO |
| beatReq | output | 1 | Request for one dword beat |
| beatAck | input | 1 | Bus master accepts the requested beat |
| beatAddr | output | 32 | Byte address of the current beat |
| burstDwords | output | 8 | Decoded burst length in dwords |
| irq | output | 1 | Period interrupt pending |

## Verification
The assertions take for granted that `beatAck` only matters while `beatReq` is high. They also assume that the start and protection addresses are dword aligned, with the protection address above the start, so the advancing pointer meets the protection address exactly. The stimulus programs aligned, ordered addresses before it enables transfers. It reprograms the protection address only while transfers are disabled. It holds `fifoLevel` at or above the threshold whenever it acknowledges beats.

// File: rtl/adg_pkg.sv
package adg_pkg;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_STATUS = 3'd1;
  localparam logic [2:0] REG_BASE   = 3'd2;
  localparam logic [2:0] REG_PROT   = 3'd3;
  localparam logic [2:0] REG_PAGE   = 3'd4;
  localparam logic [2:0] REG_CFG    = 3'd5;
  localparam logic [2:0] REG_PTR    = 3'd6;
  localparam logic [2:0] REG_OFFSET = 3'd7;

  typedef struct packed {
    logic       loadBase;
    logic       loadProt;
    logic       step;
    logic       reload;
    logic [3:0] limitCode;
  } dpCmd_t;

  function automatic logic [4:0] thrCount(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [7:0] burstCount(input logic [2:0] code);
    return 8'd1 << code;
  endfunction

endpackage

// File: rtl/adg_ctrl.sv
module adg_ctrl
  import adg_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          regWrEn,
  input  logic [2:0]    regAddr,
  input  logic [AW-1:0] regWrData,
  input  logic [LW-1:0] fifoLevel,
  input  logic          beatAck,
  input  logic          crossHit,
  output dpCmd_t        cmd,
  output logic          beatReq,
  output logic [7:0]    burstDwords,
  output logic [15:0]   ctrlWord,
  output logic          pendIrq,
  output logic          mmuEn,
  output logic [3:0]    limitCode,
  output logic [2:0]    burstCode,
  output logic [1:0]    thrCode
);

  localparam int HALF = 16;

  logic [HALF-1:0] wrMask;
  logic [HALF-1:0] wrBits;
  logic            xferEn;
  logic            wrCtrl, wrStatus, wrBase, wrProt, wrPage, wrCfg;
  logic [LW-1:0]   thrNeed;

  assign wrMask   = regWrData[2*HALF-1:HALF];
  assign wrBits   = regWrData[HALF-1:0];
  assign wrCtrl   = regWrEn && (regAddr == REG_CTRL);
  assign wrStatus = regWrEn && (regAddr == REG_STATUS);
  assign wrBase   = regWrEn && (regAddr == REG_BASE);
  assign wrProt   = regWrEn && (regAddr == REG_PROT);
  assign wrPage   = regWrEn && (regAddr == REG_PAGE);
  assign wrCfg    = regWrEn && (regAddr == REG_CFG);
  assign xferEn   = ctrlWord[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlWord  <= '0;
      pendIrq   <= 1'b0;
      mmuEn     <= 1'b0;
      limitCode <= '0;
      burstCode <= '0;
      thrCode   <= '0;
    end else begin
      if (wrCtrl) ctrlWord <= (ctrlWord & ~wrMask) | (wrBits & wrMask);
      pendIrq <= crossHit | (pendIrq & ~(wrStatus & regWrData[0]));
      if (wrPage) begin
        mmuEn     <= regWrData[11];
        limitCode <= regWrData[7:4];
      end
      if (wrCfg) begin
        burstCode <= regWrData[2:0];
        thrCode   <= regWrData[5:4];
      end
    end
  end

  assign thrNeed     = LW'(thrCount(thrCode));
  assign beatReq     = xferEn && !mmuEn && (fifoLevel >= thrNeed);
  assign burstDwords = burstCount(burstCode);

  always_comb begin
    cmd.loadBase  = wrBase;
    cmd.loadProt  = wrProt;
    cmd.step      = beatReq && beatAck;
    cmd.reload    = wrBase && !xferEn;
    cmd.limitCode = limitCode;
  end

endmodule

// File: rtl/adg_dp.sv
module adg_dp
  import adg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  dpCmd_t        cmd,
  input  logic [AW-1:0] wrData,
  output logic [AW-1:0] baseAddr,
  output logic [AW-1:0] protAddr,
  output logic [AW-1:0] curPtr,
  output logic [AW-1:0] offset,
  output logic          crossHit
);

  localparam logic [AW-1:0] STEP_BYTES = AW'(4);
  localparam int            MIN_SHIFT  = 5;

  logic [AW-1:0] sumPtr;
  logic [AW-1:0] lowMask;
  logic [AW-1:0] rawOff;
  logic [AW-1:0] bufSize;

  assign sumPtr  = curPtr + STEP_BYTES;
  assign lowMask = (AW'(1) << (MIN_SHIFT + int'(cmd.limitCode))) - AW'(1);
  assign crossHit = cmd.step && (cmd.limitCode != 4'd0) && ((sumPtr & lowMask) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAddr <= '0;
      protAddr <= '0;
      curPtr   <= '0;
    end else begin
      if (cmd.loadBase) baseAddr <= wrData;
      if (cmd.loadProt) protAddr <= wrData;
      if (cmd.reload)       curPtr <= wrData;
      else if (cmd.step)    curPtr <= (sumPtr == protAddr) ? baseAddr : sumPtr;
    end
  end

  assign rawOff  = curPtr - baseAddr;
  assign bufSize = protAddr - baseAddr;
  assign offset  = (rawOff == bufSize) ? '0 : rawOff;

endmodule

// File: rtl/audio_dma_addrgen.sv
module audio_dma_addrgen
  import adg_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          regWrEn,
  input  logic [2:0]    regAddr,
  input  logic [AW-1:0] regWrData,
  output logic [AW-1:0] regRdData,
  input  logic [LW-1:0] fifoLevel,
  output logic          beatReq,
  input  logic          beatAck,
  output logic [AW-1:0] beatAddr,
  output logic [7:0]    burstDwords,
  output logic          irq
);

  dpCmd_t        cmd;
  logic          crossHit;
  logic [15:0]   ctrlWord;
  logic          pendIrq;
  logic          mmuEn;
  logic [3:0]    limitCode;
  logic [2:0]    burstCode;
  logic [1:0]    thrCode;
  logic [AW-1:0] baseAddr, protAddr, curPtr, offset;
  logic          xferEn;

  adg_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk, .rst, .regWrEn, .regAddr, .regWrData, .fifoLevel, .beatAck,
    .crossHit, .cmd, .beatReq, .burstDwords, .ctrlWord, .pendIrq,
    .mmuEn, .limitCode, .burstCode, .thrCode
  );

  adg_dp #(.AW(AW)) u_dp (
    .clk, .rst, .cmd, .wrData(regWrData), .baseAddr, .protAddr,
    .curPtr, .offset, .crossHit
  );

  assign xferEn   = ctrlWord[0];
  assign beatAddr = curPtr;
  assign irq      = pendIrq;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL:   regRdData[15:0] = ctrlWord;
      REG_STATUS: regRdData[0]    = pendIrq;
      REG_BASE:   regRdData       = baseAddr;
      REG_PROT:   regRdData       = protAddr;
      REG_PAGE: begin
        regRdData[11]  = mmuEn;
        regRdData[7:4] = limitCode;
      end
      REG_CFG: begin
        regRdData[2:0] = burstCode;
        regRdData[5:4] = thrCode;
      end
      REG_PTR:    regRdData       = curPtr;
      default:    regRdData       = offset;
    endcase
  end

endmodule

// File: rtl/audio_dma_addrgen_chk.sv
module audio_dma_addrgen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          regWrEn,
  input logic [2:0]    regAddr,
  input logic          beatReq,
  input logic          beatAck,
  input logic [AW-1:0] beatAddr,
  input logic [AW-1:0] baseAddr,
  input logic [AW-1:0] protAddr,
  input logic          xferEn,
  input logic          mmuEn,
  input logic          irq
);

  logic baseReload;
  assign baseReload = regWrEn && (regAddr == 3'd2) && !xferEn;

  // R1
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq && !beatReq));

  // R3
  assert_req_gated_R3: assert property (@(posedge clk) disable iff (rst)
    beatReq |-> (xferEn && !mmuEn));

  // R4
  assert_step_four_R4: assert property (@(posedge clk) disable iff (rst)
    (beatReq && beatAck && !baseReload && (beatAddr + AW'(4) != protAddr))
      |=> (beatAddr == $past(beatAddr) + AW'(4)));

  // R4 / R8
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!(beatReq && beatAck) && !baseReload) |=> $stable(beatAddr));

  // R5
  assert_wrap_base_R5: assert property (@(posedge clk) disable iff (rst)
    (beatReq && beatAck && (beatAddr + AW'(4) == protAddr))
      |=> (beatAddr == $past(baseAddr)));

  // R6
  assert_irq_from_beat_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(beatReq && beatAck));

endmodule

bind audio_dma_addrgen audio_dma_addrgen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
  .beatReq(beatReq), .beatAck(beatAck), .beatAddr(beatAddr),
  .baseAddr(baseAddr), .protAddr(protAddr), .xferEn(xferEn),
  .mmuEn(mmuEn), .irq(irq)
);

// File: tb/sim_audio_dma_addrgen.sv
module sim_audio_dma_addrgen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  fifoLevel = 8'd16;
  logic        beatReq;
  logic        beatAck = 1'b0;
  logic [31:0] beatAddr;
  logic [7:0]  burstDwords;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  audio_dma_addrgen u0 (
    .clk, .rst, .regWrEn, .regAddr, .regWrData, .regRdData, .fifoLevel,
    .beatReq, .beatAck, .beatAddr, .burstDwords, .irq
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic beats(input int n);
    @(negedge clk);
    beatAck = 1'b1;
    repeat (n) @(negedge clk);
    beatAck = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd1, v); check("R1 status", v, 32'h0);
    rd(3'd6, v); check("R1 pointer", v, 32'h0);
    check("R1 beatReq", {31'b0, beatReq}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(3'd0, 32'h0000_0001); rd(3'd0, v); check("R2 unmasked write", v, 32'h0);
    wr(3'd0, 32'h0001_0001); rd(3'd0, v); check("R2 masked set", v, 32'h1);
    wr(3'd0, 32'h0000_0000); rd(3'd0, v); check("R2 no mask keeps", v, 32'h1);
    wr(3'd0, 32'h0001_0000); rd(3'd0, v); check("R2 masked clear", v, 32'h0);
  endtask

  task automatic t_setup();
    logic [31:0] v;
    wr(3'd3, 32'h0000_1080);
    wr(3'd4, 32'h0000_0010);
    wr(3'd5, 32'h0000_0013);
    check("R9 burst code 3", {24'b0, burstDwords}, 32'd8);
    wr(3'd2, 32'h0000_1000);
    rd(3'd6, v); check("R8 reload while disabled", v, 32'h1000);
  endtask

  task automatic t_gating();
    fifoLevel = 8'd3;
    wr(3'd0, 32'h0001_0001);
    #1 check("R3 below threshold", {31'b0, beatReq}, 32'h0);
    fifoLevel = 8'd4;
    #1 check("R3 at threshold", {31'b0, beatReq}, 32'h1);
    wr(3'd4, 32'h0000_0810);
    #1 check("R3 paging bit blocks", {31'b0, beatReq}, 32'h0);
    wr(3'd4, 32'h0000_0010);
    #1 check("R3 paging cleared", {31'b0, beatReq}, 32'h1);
    fifoLevel = 8'd16;
  endtask

  task automatic t_advance_irq();
    logic [31:0] v;
    beats(15);
    rd(3'd6, v); check("R4 after 15 beats", v, 32'h103C);
    check("R6 no irq before boundary", {31'b0, irq}, 32'h0);
    @(negedge clk); rd(3'd6, v); check("R4 holds without ack", v, 32'h103C);
    beats(1);
    rd(3'd6, v); check("R4 after 16 beats", v, 32'h1040);
    check("R6 irq at 64B boundary", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h0); check("R7 write zero keeps", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h1); check("R7 write one clears", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    beats(15);
    rd(3'd6, v); check("R5 before wrap", v, 32'h107C);
    beats(1);
    rd(3'd6, v); check("R5 wrapped to base", v, 32'h1000);
    check("R6 irq at wrap boundary", {31'b0, irq}, 32'h1);
    rd(3'd7, v); check("R10 offset after wrap", v, 32'h0);
    wr(3'd1, 32'h1);
    beats(3);
    rd(3'd7, v); check("R10 offset", v, 32'h000C);
  endtask

  task automatic t_offset_full();
    logic [31:0] v;
    wr(3'd0, 32'h0001_0000);
    wr(3'd3, 32'h0000_100C);
    rd(3'd7, v); check("R10 offset equal to size reads 0", v, 32'h0);
    rd(3'd6, v); check("R10 pointer unaffected", v, 32'h100C);
    wr(3'd6, 32'h0000_DEAD);
    rd(3'd6, v); check("R8 pointer register write ignored", v, 32'h100C);
    wr(3'd3, 32'h0000_1080);
    wr(3'd0, 32'h0001_0001);
  endtask

  task automatic t_limit0();
    logic [31:0] v;
    wr(3'd4, 32'h0000_0000);
    beats(32);
    rd(3'd6, v); check("R5 pointer after 32 beats", v, 32'h100C);
    check("R6 limit 0 raises nothing", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_limit2();
    logic [31:0] v;
    wr(3'd4, 32'h0000_0020);
    beats(13);
    rd(3'd6, v); check("R4 at 0x1040", v, 32'h1040);
    check("R6 limit 2 ignores 64B boundary", {31'b0, irq}, 32'h0);
    beats(16);
    rd(3'd6, v); check("R5 wrap with limit 2", v, 32'h1000);
    check("R6 limit 2 at 128B boundary", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_base_enabled();
    logic [31:0] v;
    wr(3'd2, 32'h0000_2000);
    rd(3'd6, v); check("R8 base write while enabled keeps pointer", v, 32'h1000);
    wr(3'd0, 32'h0001_0000);
    wr(3'd2, 32'h0000_1000);
    wr(3'd0, 32'h0001_0001);
  endtask

  task automatic t_set_beats_clear();
    logic [31:0] v;
    wr(3'd4, 32'h0000_0010);
    beats(15);
    check("R7 still pending", {31'b0, irq}, 32'h1);
    @(negedge clk);
    beatAck = 1'b1; regWrEn = 1'b1; regAddr = 3'd1; regWrData = 32'h1;
    @(negedge clk);
    beatAck = 1'b0; regWrEn = 1'b0;
    check("R7 set wins over clear", {31'b0, irq}, 32'h1);
    rd(3'd6, v); check("R4 pointer at 0x1040", v, 32'h1040);
    wr(3'd1, 32'h1);
    check("R7 cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_burst();
    wr(3'd5, 32'h0000_0000);
    check("R9 burst code 0", {24'b0, burstDwords}, 32'd1);
    wr(3'd5, 32'h0000_0007);
    check("R9 burst code 7", {24'b0, burstDwords}, 32'd128);
    wr(3'd5, 32'h0000_0030);
    fifoLevel = 8'd15;
    #1 check("R3 threshold 16 not met", {31'b0, beatReq}, 32'h0);
    fifoLevel = 8'd16;
    #1 check("R3 threshold 16 met", {31'b0, beatReq}, 32'h1);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 beatReq after reset", {31'b0, beatReq}, 32'h0);
    check("R1 pointer after reset", beatAddr, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask();
    t_setup();
    t_gating();
    t_advance_irq();
    t_wrap();
    t_offset_full();
    t_limit0();
    t_limit2();
    t_base_enabled();
    t_set_beats_clear();
    t_burst();
    t_reset_again();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule